// File: doc/BRIEF.md
# Invalidation Acknowledgement Tracker

This block follows a single outstanding write miss in a private cache controller. It sorts every incoming coherence response into one event for the controller's state machine and keeps a running count of the invalidation acknowledgements still owed. The directory's data reply carries the number of sharers that must acknowledge. Those acknowledgements travel on their own paths, so some or all of them can arrive before the directory data. The tracker handles this with a signed counter. Each early acknowledgement pushes the counter below zero. When the directory data finally arrives, the counter is reconciled by adding the ack count the data carries.

The controller pulses `txn_start` when it allocates a transaction entry. Responses then arrive one per cycle on the `rsp_*` inputs. One cycle later the tracker presents either a classified event or an error pulse, together with the updated count. Three events complete the transaction and return the count to zero: directory data with nothing owed, data from the owning cache, and the last acknowledgement. Protocol violations never produce an event. They leave the count as it was.

Top module: `inv_ack_tracker`

## Requirements
- R1: After reset, `pending_acks` is 0, and `evt_valid` and `proto_err` are both 0.
- R2: An acknowledgement from a cache (`rsp_from_dir`=0, `rsp_kind`=1) that arrives while the count is not 1 gives event code 3 (plain ack) and lowers the count by one, which can take it below zero.
- R3: Directory data (`rsp_from_dir`=1, `rsp_kind`=0) whose `rsp_acks` plus the count equals zero gives event code 0 (data, nothing owed) and leaves the count at 0.
- R4: Directory data whose sum is between 1 and `MAX_SHARERS` gives event code 1 (data, acks owed) and loads the count with that sum.
- R5: An acknowledgement from a cache that arrives while the count is exactly 1 gives event code 4 (last ack) and clears the count to 0.
- R6: Data from a cache (`rsp_from_dir`=0, `rsp_kind`=0) gives event code 2 (owner data) whatever the count is, and clears the count to 0.
- R7: A directory response whose kind is not 0, or a cache response whose kind is 2 or 3, raises `proto_err` for one cycle with no event and no change to the count.
- R8: Directory data whose sum is negative or greater than `MAX_SHARERS` raises `proto_err` with no event and no change to the count.
- R9: An acknowledgement that would take the count below `-MAX_SHARERS` raises `proto_err` with no event and no change to the count.
- R10: `txn_start` clears the count to 0. A response in the same cycle is classified against a count of 0.
- R11: Each event or error appears exactly one cycle after its response cycle. A cycle without `rsp_valid` produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | New transaction allocated; clears the count |
| rsp_valid | input | 1 | A response is presented this cycle |
| rsp_from_dir | input | 1 | 1 = sender is the directory, 0 = another cache |
| rsp_kind | input | 2 | 0 = data, 1 = invalidation ack, 2 and 3 are illegal |
| rsp_acks | input | ACK_W | Ack count carried by directory data |
| evt_valid | output | 1 | An event is presented this cycle |
| evt_code | output | 3 | 0 dir data no acks, 1 dir data with acks, 2 owner data, 3 ack, 4 last ack |
| proto_err | output | 1 | Protocol violation on the previous response |
| pending_acks | output | CNT_W | Signed count of acknowledgements still owed |

## Verification
A wrong count stays hidden until it changes a classification. A count that is off by one turns the final acknowledgement into a plain ack, or turns a "nothing owed" data reply into an "acks owed" one. That shows up only when the mis-tracked transaction reaches its last response, which can be many cycles later. `pending_acks` is visible on the ports, so the bench compares it with a behavioural model every cycle and catches a corrupted count on the cycle after the response that corrupted it. Sequences with acknowledgements arriving both before and after the data, along with deliberate overflow and illegal-kind responses, drive the count through its whole signed range.

// File: rtl/ack_trk_pkg.sv
// Package: shared types for the invalidation-ack tracker.
// Assumes: event codes are decoded by the consuming controller as listed.
package ack_trk_pkg;

    typedef enum logic [2:0] {
        EV_DIR_NOACK = 3'd0,
        EV_DIR_ACKS  = 3'd1,
        EV_OWNER     = 3'd2,
        EV_ACK       = 3'd3,
        EV_LAST_ACK  = 3'd4
    } trk_event_e;

    typedef enum logic [1:0] {
        RK_DATA = 2'd0,
        RK_INV  = 2'd1
    } rsp_kind_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_DEC   = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/ack_classify.sv
// Module: ack_classify
// Turns one response and the effective ack count into an event, an error
// flag and a counter operation. Purely combinational.
// Assumes: cnt_eff already reflects a same-cycle transaction start.
module ack_classify
    import ack_trk_pkg::*;
#(
    parameter int MAX_SHARERS = 15,
    parameter int ACK_W       = $clog2(MAX_SHARERS + 1),
    parameter int CNT_W       = ACK_W + 1
) (
    input  logic                    rsp_valid,
    input  logic                    rsp_from_dir,
    input  logic [1:0]              rsp_kind,
    input  logic [ACK_W-1:0]        rsp_acks,
    input  logic signed [CNT_W-1:0] cnt_eff,
    output logic                    evt_fire,
    output trk_event_e              evt_code,
    output logic                    err,
    output cnt_op_e                 cnt_op,
    output logic signed [CNT_W-1:0] load_val
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(MAX_SHARERS);
    localparam logic signed [CNT_W-1:0] CNT_MIN = CNT_W'(-MAX_SHARERS);
    localparam logic signed [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic signed [SUM_W-1:0] sum;

    // Reconciled count: carried acks plus acks already seen (negative).
    always_comb begin
        sum = $signed({{(SUM_W-ACK_W){1'b0}}, rsp_acks}) + SUM_W'(cnt_eff);
    end

    // Decide the event, the error and what the counter does next.
    always_comb begin
        evt_fire = 1'b0;
        evt_code = EV_DIR_NOACK;
        err      = 1'b0;
        cnt_op   = OP_HOLD;
        load_val = CNT_W'(sum);
        if (rsp_valid) begin
            if (rsp_from_dir) begin
                if (rsp_kind != RK_DATA) begin
                    err = 1'b1;
                end else if (sum < 0 || sum > SUM_MAX) begin
                    err = 1'b1;
                end else if (sum == 0) begin
                    evt_fire = 1'b1;
                    evt_code = EV_DIR_NOACK;
                    cnt_op   = OP_CLEAR;
                end else begin
                    evt_fire = 1'b1;
                    evt_code = EV_DIR_ACKS;
                    cnt_op   = OP_LOAD;
                end
            end else begin
                if (rsp_kind == RK_DATA) begin
                    evt_fire = 1'b1;
                    evt_code = EV_OWNER;
                    cnt_op   = OP_CLEAR;
                end else if (rsp_kind == RK_INV) begin
                    if (cnt_eff == CNT_ONE) begin
                        evt_fire = 1'b1;
                        evt_code = EV_LAST_ACK;
                        cnt_op   = OP_CLEAR;
                    end else if (cnt_eff == CNT_MIN) begin
                        err = 1'b1;
                    end else begin
                        evt_fire = 1'b1;
                        evt_code = EV_ACK;
                        cnt_op   = OP_DEC;
                    end
                end else begin
                    err = 1'b1;
                end
            end
        end
    end

    // R7
    always_comb begin
        illegal_kind_chk: assert (!(rsp_valid && rsp_kind[1]) || (err && !evt_fire));
    end

endmodule

// File: rtl/ack_counter.sv
// Module: ack_counter
// Signed register holding the acknowledgements still owed. A start pulse
// clears it before the operation for the same cycle is applied.
// Assumes: the operation was derived from the cleared value when start is high.
module ack_counter
    import ack_trk_pkg::*;
#(
    parameter int MAX_SHARERS = 15,
    parameter int CNT_W       = $clog2(MAX_SHARERS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  cnt_op_e                 op,
    input  logic signed [CNT_W-1:0] load_val,
    output logic signed [CNT_W-1:0] cnt,
    output logic signed [CNT_W-1:0] cnt_eff
);

    localparam logic signed [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_SHARERS);

    logic signed [CNT_W-1:0] cnt_nxt;

    // Count seen by this cycle's response.
    always_comb begin
        cnt_eff = start ? '0 : cnt;
    end

    // Apply the requested counter operation.
    always_comb begin
        unique case (op)
            OP_LOAD:  cnt_nxt = load_val;
            OP_DEC:   cnt_nxt = cnt_eff - CNT_W'(1);
            OP_CLEAR: cnt_nxt = '0;
            default:  cnt_nxt = cnt_eff;
        endcase
    end

    // Counter register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_LIM) && (cnt >= -CNT_LIM));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_HOLD) |=> (cnt == 0));

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && op == OP_DEC) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/inv_ack_tracker.sv
// Module: inv_ack_tracker (top)
// Classifies coherence responses for one in-flight write miss and tracks
// the signed invalidation-ack count. Events and errors are registered and
// appear the cycle after their response.
// Assumes: at most one response per cycle; txn_start marks allocation.
module inv_ack_tracker
    import ack_trk_pkg::*;
#(
    parameter int MAX_SHARERS = 15,
    parameter int ACK_W       = $clog2(MAX_SHARERS + 1),
    parameter int CNT_W       = ACK_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    txn_start,
    input  logic                    rsp_valid,
    input  logic                    rsp_from_dir,
    input  logic [1:0]              rsp_kind,
    input  logic [ACK_W-1:0]        rsp_acks,
    output logic                    evt_valid,
    output logic [2:0]              evt_code,
    output logic                    proto_err,
    output logic signed [CNT_W-1:0] pending_acks
);

    logic signed [CNT_W-1:0] cnt_eff;
    logic signed [CNT_W-1:0] load_val;
    logic                    c_fire;
    logic                    c_err;
    trk_event_e              c_code;
    cnt_op_e                 c_op;

    ack_counter #(
        .MAX_SHARERS (MAX_SHARERS),
        .CNT_W       (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (txn_start),
        .op       (c_op),
        .load_val (load_val),
        .cnt      (pending_acks),
        .cnt_eff  (cnt_eff)
    );

    ack_classify #(
        .MAX_SHARERS (MAX_SHARERS),
        .ACK_W       (ACK_W),
        .CNT_W       (CNT_W)
    ) u_classify (
        .rsp_valid    (rsp_valid),
        .rsp_from_dir (rsp_from_dir),
        .rsp_kind     (rsp_kind),
        .rsp_acks     (rsp_acks),
        .cnt_eff      (cnt_eff),
        .evt_fire     (c_fire),
        .evt_code     (c_code),
        .err          (c_err),
        .cnt_op       (c_op),
        .load_val     (load_val)
    );

    // Register the event and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= 3'd0;
            proto_err <= 1'b0;
        end else begin
            evt_valid <= c_fire;
            evt_code  <= c_fire ? c_code : 3'd0;
            proto_err <= c_err;
        end
    end

    // R11
    evt_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && proto_err));

    // R11
    no_rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> (!evt_valid && !proto_err));

    // R5
    last_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_LAST_ACK) |-> (pending_acks == 0));

    // R4
    load_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_DIR_ACKS) |-> (pending_acks > 0));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !txn_start && c_err) |=> $stable(pending_acks));

endmodule

// File: tb/inv_ack_tracker_bench.sv
module inv_ack_tracker_bench;

    localparam int MAXS  = 15;
    localparam int ACK_W = 4;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0;
    logic rsp_valid = 1'b0;
    logic rsp_from_dir = 1'b0;
    logic [1:0] rsp_kind = 2'd0;
    logic [ACK_W-1:0] rsp_acks = '0;
    logic evt_valid;
    logic [2:0] evt_code;
    logic proto_err;
    logic signed [CNT_W-1:0] pending_acks;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int mcnt    = 0;

    always #2 clk = ~clk;

    inv_ack_tracker #(.MAX_SHARERS(MAXS)) u_inv_ack_tracker (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start),
        .rsp_valid(rsp_valid), .rsp_from_dir(rsp_from_dir),
        .rsp_kind(rsp_kind), .rsp_acks(rsp_acks),
        .evt_valid(evt_valid), .evt_code(evt_code),
        .proto_err(proto_err), .pending_acks(pending_acks)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Apply one cycle of stimulus, model it, and compare after the edge.
    task automatic step(input logic st, input logic v, input logic dir,
                        input int kind, input int acks, input string req);
        int eff;
        int sum;
        logic ev;
        int code;
        logic er;
        eff = st ? 0 : mcnt;
        ev = 0; code = 0; er = 0;
        if (v) begin
            if (dir) begin
                sum = acks + eff;
                if (kind != 0 || sum < 0 || sum > MAXS) er = 1;
                else if (sum == 0) begin ev = 1; code = 0; eff = 0; end
                else begin ev = 1; code = 1; eff = sum; end
            end else begin
                if (kind == 0) begin ev = 1; code = 2; eff = 0; end
                else if (kind == 1) begin
                    if (eff == 1) begin ev = 1; code = 4; eff = 0; end
                    else if (eff == -MAXS) er = 1;
                    else begin ev = 1; code = 3; eff = eff - 1; end
                end else er = 1;
            end
        end
        mcnt = eff;
        txn_start = st; rsp_valid = v; rsp_from_dir = dir;
        rsp_kind = 2'(kind); rsp_acks = ACK_W'(acks);
        @(posedge clk);
        #1;
        n_tests = n_tests + 1;
        if (evt_valid !== ev || proto_err !== er ||
            (ev && int'(evt_code) != code) || int'(pending_acks) != mcnt) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got ev=%0b code=%0d err=%0b cnt=%0d exp ev=%0b code=%0d err=%0b cnt=%0d",
                     req, evt_valid, evt_code, proto_err, pending_acks, ev, code, er, mcnt);
        end
        txn_start = 0; rsp_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        n_tests = n_tests + 1;
        if (evt_valid !== 0 || proto_err !== 0 || pending_acks !== 0) begin
            n_fail = n_fail + 1;
            $display("FAIL R1: got ev=%0b err=%0b cnt=%0d exp 0 0 0", evt_valid, proto_err, pending_acks);
        end
        @(negedge clk);
        // R3: acks all arrive early, then data with matching count
        step(1, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 0, 0, 0, 0, "R11");
        step(0, 1, 1, 0, 2, "R3");
        // R4 then R2 then R5: data first, acks later
        step(1, 1, 1, 0, 3, "R4");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R5");
        // mixed: one early ack, data with 3, two late acks
        step(1, 1, 0, 1, 0, "R2");
        step(0, 1, 1, 0, 3, "R4");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R5");
        // R6 owner data at nonzero count
        step(1, 1, 1, 0, 4, "R4");
        step(0, 1, 0, 0, 0, "R6");
        // R7 illegal kinds
        step(1, 1, 1, 0, 2, "R4");
        step(0, 1, 1, 1, 0, "R7");
        step(0, 1, 0, 2, 0, "R7");
        step(0, 1, 0, 3, 0, "R7");
        step(0, 1, 1, 3, 5, "R7");
        // R8 negative sum and oversized sum
        step(1, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 1, 0, 1, "R8");
        step(1, 1, 1, 0, 15, "R4");
        step(0, 1, 1, 0, 1, "R8");
        // R9 underflow at -MAXS
        step(1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < MAXS; i++) step(0, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R9");
        step(0, 1, 1, 0, 15, "R3");
        // R10 start with response classified against zero
        step(1, 1, 0, 1, 0, "R2");
        step(0, 1, 0, 1, 0, "R2");
        step(1, 1, 1, 0, 0, "R10");
        // random stream
        for (int i = 0; i < 400; i++) begin
            int k;
            k = ($urandom % 10 < 7) ? 1 : (($urandom % 4 == 0) ? int'($urandom % 4) : 0);
            step(($urandom % 12) == 0, ($urandom % 5) != 0, ($urandom % 4) == 0,
                 k, int'($urandom % 6), "R11");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule